// File: doc/BRIEF.md
# Decode-Stage Register Tracking Table

This block sits directly after instruction decode and looks at one decoded instruction per clock, in program order. For every integer register it records whether the register's value can be stated exactly. A register that can be stated is held as a pair: a base register and a constant offset. Chains of add-immediate operations fold into one offset on a shared base. The table also keeps one committed value per register. When a load or store uses base-plus-displacement addressing and its source register can be stated, the block produces the full effective address with a single adder. The load's symbolic base and offset are also sent out for memory disambiguation.

Any other register write, and any add-immediate whose source cannot be stated, marks the destination as unknown. Every register that depends on that destination as its base is cleared in the same cycle. The back-end later reports the committed value of such an untracked write on a commit port. The entry then becomes known again, with itself as base and zero offset. A per-register count of outstanding untracked writes makes sure that only the youngest of them reloads the entry. Register 0 always reads as known zero.

Decode fields arrive already extracted. The operation code `dec_op` uses 00 for another operation, 01 for add-immediate, 10 for load and 11 for store.

Top module: `reg_track_table`

## Requirements
- R1: After reset, registers 1 to 31 cannot be stated and register 0 is known as zero. A memory operation based on register 0 reports tracked, base 0, and an address equal to its displacement.
- R2: An add-immediate (`dec_op`=01) whose source can be stated gives its destination the source's base and the source's offset plus the immediate. The immediate is zero-extended from 16 bits when `dec_imm_uns`=1 and sign-extended from bit 15 otherwise.
- R3: An add-immediate whose source cannot be stated leaves its destination unknown.
- R4: A load (`dec_op`=10) and another operation (`dec_op`=00) with `dec_wr`=1 leave their destination unknown. A store (`dec_op`=11), and `dec_op`=00 with `dec_wr`=0, change no entry.
- R5: When a destination is made unknown, every other entry whose base is that destination also becomes unknown in the same cycle.
- R6: A commit of register r with value v, where r has exactly one outstanding untracked write and r is unknown, makes r known with base r, offset 0 and committed value v. Otherwise the commit only retires one outstanding untracked write and changes no entry.
- R7: When a decode write and a commit name the same register in the same cycle, the decode write decides that entry.
- R8: One cycle after a load or store is decoded, `mem_valid` is 1 and `mem_is_store` shows the kind of operation. `mem_tracked` shows whether the source could be stated. When it is tracked, `mem_base` is the entry's base, `mem_offset` is the entry's offset plus the sign-extended displacement, and `mem_ea` is the base's committed value plus `mem_offset`. When it is untracked, all three are 0. `mem_valid` is 0 in every other cycle.
- R9: Decode writes and commits naming register 0 have no effect.
- R10: A register has at most 2^PEND_W-1 outstanding untracked writes, and the back-end commits only registers that have at least one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_op | input | 2 | 00 other, 01 add-immediate, 10 load, 11 store |
| dec_wr | input | 1 | For `dec_op`=00: the instruction writes `dec_rd` |
| dec_rd | input | 5 | Destination register |
| dec_rs | input | 5 | Source or base register |
| dec_imm | input | 16 | Immediate or displacement |
| dec_imm_uns | input | 1 | Zero-extend the add-immediate operand |
| cmt_valid | input | 1 | Back-end commits an untracked write |
| cmt_rd | input | 5 | Committed destination register |
| cmt_value | input | 32 | Committed value |
| mem_valid | output | 1 | Memory-operation result is present |
| mem_is_store | output | 1 | Result belongs to a store |
| mem_tracked | output | 1 | Address could be computed |
| mem_ea | output | 32 | Effective address |
| mem_base | output | 5 | Symbolic base register |
| mem_offset | output | 32 | Symbolic offset from the base |

## Verification
On every cycle, the assertions check these invariants: register 0 stays pinned, a trackable add-immediate leaves its destination known, dependents of an invalidated register are cleared, a reload installs a self-based entry, outputs appear only after memory operations, and the back-end honours the outstanding-write contract. Only the bench's scenarios can show that the values are right. That covers folded offsets under both immediate extensions, computed addresses, and the choice of which commit reloads an entry. It also covers the decode-over-commit priority and stale commits that are ignored. The bench checks these against a behavioural model on every clock, across directed sequences and a long random stream.

// File: rtl/reg_track_table.sv
module reg_track_table #(
  parameter int NREG   = 32,
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int PEND_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dec_valid,
  input  logic [1:0]              dec_op,
  input  logic                    dec_wr,
  input  logic [$clog2(NREG)-1:0] dec_rd,
  input  logic [$clog2(NREG)-1:0] dec_rs,
  input  logic [IMM_W-1:0]        dec_imm,
  input  logic                    dec_imm_uns,
  input  logic                    cmt_valid,
  input  logic [$clog2(NREG)-1:0] cmt_rd,
  input  logic [XLEN-1:0]         cmt_value,
  output logic                    mem_valid,
  output logic                    mem_is_store,
  output logic                    mem_tracked,
  output logic [XLEN-1:0]         mem_ea,
  output logic [$clog2(NREG)-1:0] mem_base,
  output logic [XLEN-1:0]         mem_offset
);
  localparam int RW = $clog2(NREG);
  localparam logic [1:0] OP_OTHER = 2'b00;
  localparam logic [1:0] OP_ADDI  = 2'b01;
  localparam logic [1:0] OP_LOAD  = 2'b10;
  localparam logic [1:0] OP_STORE = 2'b11;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic            trk  [NREG];
  logic [RW-1:0]   bse  [NREG];
  logic [XLEN-1:0] off  [NREG];
  logic [XLEN-1:0] kv   [NREG];
  logic [PEND_W-1:0] pend [NREG];

  logic [XLEN-1:0] imm_ext, disp_ext, upd_off, mem_off_c;
  logic is_addi, is_mem, wr, new_trk, kill, cmt_ok, reload, src_trk;

  assign src_trk   = trk[dec_rs];
  assign imm_ext   = dec_imm_uns ? {{(XLEN-IMM_W){1'b0}}, dec_imm}
                                 : {{(XLEN-IMM_W){dec_imm[IMM_W-1]}}, dec_imm};
  assign disp_ext  = {{(XLEN-IMM_W){dec_imm[IMM_W-1]}}, dec_imm};
  assign upd_off   = off[dec_rs] + imm_ext;
  assign mem_off_c = off[dec_rs] + disp_ext;

  assign is_addi = dec_valid && dec_op == OP_ADDI;
  assign is_mem  = dec_valid && dec_op[1];
  assign wr      = dec_valid && dec_rd != '0 &&
                   (dec_op == OP_ADDI || dec_op == OP_LOAD || (dec_op == OP_OTHER && dec_wr));
  assign new_trk = is_addi && src_trk;
  assign kill    = wr && !new_trk;
  assign cmt_ok  = cmt_valid && cmt_rd != '0;
  assign reload  = cmt_ok && !(wr && dec_rd == cmt_rd) &&
                   pend[cmt_rd] == PEND_W'(1) && !trk[cmt_rd];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        trk[i]  <= (i == 0);
        bse[i]  <= RW'(i);
        off[i]  <= '0;
        kv[i]   <= '0;
        pend[i] <= '0;
      end
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (wr && dec_rd == RW'(i)) begin
          trk[i] <= new_trk;
          if (new_trk) begin
            bse[i] <= bse[dec_rs];
            off[i] <= upd_off;
          end
        end else if (reload && cmt_rd == RW'(i)) begin
          trk[i] <= 1'b1;
          bse[i] <= RW'(i);
          off[i] <= '0;
          kv[i]  <= cmt_value;
        end else if (kill && bse[i] == dec_rd) begin
          trk[i] <= 1'b0;
        end
        pend[i] <= pend[i] + PEND_W'(kill && dec_rd == RW'(i))
                           - PEND_W'(cmt_ok && cmt_rd == RW'(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid    <= 1'b0;
      mem_is_store <= 1'b0;
      mem_tracked  <= 1'b0;
      mem_ea       <= '0;
      mem_base     <= '0;
      mem_offset   <= '0;
    end else begin
      mem_valid    <= is_mem;
      mem_is_store <= is_mem && dec_op == OP_STORE;
      mem_tracked  <= is_mem && src_trk;
      if (is_mem && src_trk) begin
        mem_base   <= bse[dec_rs];
        mem_offset <= mem_off_c;
        mem_ea     <= kv[bse[dec_rs]] + mem_off_c;
      end else begin
        mem_base   <= '0;
        mem_offset <= '0;
        mem_ea     <= '0;
      end
    end
  end

  // R9
  r0_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk[0] && bse[0] == '0 && off[0] == '0 && kv[0] == '0);

  // R2
  addi_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && new_trk) |=> trk[$past(dec_rd)]);

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> trk[$past(cmt_rd)] && bse[$past(cmt_rd)] == $past(cmt_rd)
               && off[$past(cmt_rd)] == '0 && kv[$past(cmt_rd)] == $past(cmt_value));

  // R8
  mem_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $past(dec_valid) && $past(dec_op[1]));

  // R10
  pend_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(kill && pend[dec_rd] == PEND_MAX && !(cmt_ok && cmt_rd == dec_rd)));

  // R10
  cmt_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_ok |-> pend[cmt_rd] != '0);

  for (genvar g = 1; g < NREG; g++) begin : g_casc
    // R5
    cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && bse[g] == dec_rd && dec_rd != RW'(g) && !(reload && cmt_rd == RW'(g)))
        |=> !trk[g]);
  end
endmodule

// File: tb/reg_track_table_test.sv
`timescale 1ns/1ps
module reg_track_table_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, dec_wr = 1'b0, dec_imm_uns = 1'b0, cmt_valid = 1'b0;
  logic [1:0] dec_op = 2'b00;
  logic [4:0] dec_rd = '0, dec_rs = '0, cmt_rd = '0;
  logic [15:0] dec_imm = '0;
  logic [31:0] cmt_value = '0;
  logic mem_valid, mem_is_store, mem_tracked;
  logic [31:0] mem_ea, mem_offset;
  logic [4:0] mem_base;

  always #2.5 clk = ~clk;

  reg_track_table uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op), .dec_wr(dec_wr),
    .dec_rd(dec_rd), .dec_rs(dec_rs), .dec_imm(dec_imm), .dec_imm_uns(dec_imm_uns),
    .cmt_valid(cmt_valid), .cmt_rd(cmt_rd), .cmt_value(cmt_value),
    .mem_valid(mem_valid), .mem_is_store(mem_is_store), .mem_tracked(mem_tracked),
    .mem_ea(mem_ea), .mem_base(mem_base), .mem_offset(mem_offset));

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit done = 0;

  logic        m_trk [32];
  logic [4:0]  m_bs  [32];
  logic [31:0] m_of  [32];
  logic [31:0] m_kv  [32];
  int          m_pd  [32];
  logic e_v, e_s, e_t;
  logic [4:0] e_b;
  logic [31:0] e_ea, e_of;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int j = 0; j < 32; j++) begin
      m_trk[j] = (j == 0); m_bs[j] = 5'(j); m_of[j] = 0; m_kv[j] = 0; m_pd[j] = 0;
    end
    e_v = 0; e_s = 0; e_t = 0; e_b = 0; e_ea = 0; e_of = 0;
  endtask

  task automatic model_step();
    logic [31:0] sx, ix, so;
    logic [4:0] sb;
    logic wrm, nt, reld;
    sx = {{16{dec_imm[15]}}, dec_imm};
    ix = dec_imm_uns ? {16'h0, dec_imm} : sx;
    e_v = dec_valid && dec_op[1];
    e_s = e_v && dec_op == 2'b11;
    e_t = e_v && m_trk[dec_rs];
    e_b = e_t ? m_bs[dec_rs] : 5'd0;
    e_of = e_t ? m_of[dec_rs] + sx : 32'd0;
    e_ea = e_t ? m_kv[m_bs[dec_rs]] + m_of[dec_rs] + sx : 32'd0;
    sb = m_bs[dec_rs];
    so = m_of[dec_rs] + ix;
    wrm = dec_valid && dec_rd != 0 &&
          (dec_op == 2'b01 || dec_op == 2'b10 || (dec_op == 2'b00 && dec_wr));
    nt = dec_valid && dec_op == 2'b01 && m_trk[dec_rs];
    reld = 0;
    if (cmt_valid && cmt_rd != 0) begin
      reld = !(wrm && dec_rd == cmt_rd) && m_pd[cmt_rd] == 1 && !m_trk[cmt_rd];
      m_pd[cmt_rd]--;
    end
    if (wrm) begin
      if (nt) begin
        m_trk[dec_rd] = 1; m_bs[dec_rd] = sb; m_of[dec_rd] = so;
      end else begin
        m_trk[dec_rd] = 0; m_pd[dec_rd]++;
        for (int j = 1; j < 32; j++)
          if (j != dec_rd && m_bs[j] == dec_rd && !(reld && j == cmt_rd)) m_trk[j] = 0;
      end
    end
    if (reld) begin
      m_trk[cmt_rd] = 1; m_bs[cmt_rd] = cmt_rd; m_of[cmt_rd] = 0; m_kv[cmt_rd] = cmt_value;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    chk("mem_valid", 32'(mem_valid), 32'(e_v));
    if (e_v) begin
      chk("mem_is_store", 32'(mem_is_store), 32'(e_s));
      chk("mem_tracked", 32'(mem_tracked), 32'(e_t));
      chk("mem_ea", mem_ea, e_ea);
      chk("mem_base", 32'(mem_base), 32'(e_b));
      chk("mem_offset", mem_offset, e_of);
    end
    dec_valid = 0; cmt_valid = 0; dec_wr = 0; dec_imm_uns = 0;
  endtask

  task automatic op(input logic [1:0] o, input int rd, input int rs, input logic [15:0] imm,
                    input logic uns = 0, input logic w = 0);
    dec_valid = 1; dec_op = o; dec_rd = 5'(rd); dec_rs = 5'(rs);
    dec_imm = imm; dec_imm_uns = uns; dec_wr = w;
  endtask

  task automatic cmt(input int rd, input logic [31:0] v);
    cmt_valid = 1; cmt_rd = 5'(rd); cmt_value = v;
  endtask

  initial begin
    model_reset();
    repeat (3) tick();
    cur_req = "R1";
    chk("mem_valid in reset", 32'(mem_valid), 0);
    @(negedge clk); rst_n = 1;
    op(2'b10, 3, 0, 16'h0010); tick();
    op(2'b10, 4, 5, 16'h0004); tick();
    cur_req = "R2";
    op(2'b01, 5, 0, 16'h0100); tick();
    op(2'b01, 6, 5, 16'hFFF0); tick();
    op(2'b01, 7, 6, 16'h8000, 1); tick();
    op(2'b10, 11, 7, 16'h0004); tick();
    op(2'b11, 0, 6, 16'h8000); tick();
    cur_req = "R6";
    op(2'b00, 8, 1, 16'h0, 0, 1); tick();
    cmt(8, 32'h0000_4000); tick();
    op(2'b10, 12, 8, 16'hFFF8); tick();
    cur_req = "R5";
    op(2'b01, 9, 8, 16'h0020); tick();
    op(2'b11, 0, 9, 16'h0000); tick();
    op(2'b00, 8, 2, 16'h0, 0, 1); tick();
    op(2'b11, 0, 9, 16'h0000); tick();
    cmt(8, 32'h0000_7000); tick();
    op(2'b10, 13, 9, 16'h0); tick();
    op(2'b10, 13, 8, 16'h2); tick();
    cur_req = "R3";
    op(2'b01, 10, 9, 16'h0004); tick();
    op(2'b11, 0, 10, 16'h0); tick();
    cmt(10, 32'h123); tick();
    op(2'b11, 0, 10, 16'h1); tick();
    cur_req = "R4";
    op(2'b00, 5, 1, 16'h0, 0, 0); tick();
    op(2'b11, 5, 5, 16'h0008); tick();
    op(2'b11, 0, 5, 16'h0008); tick();
    op(2'b10, 5, 5, 16'h0000); tick();
    op(2'b11, 0, 5, 16'h0008); tick();
    cur_req = "R7";
    op(2'b00, 14, 1, 16'h0, 0, 1); tick();
    op(2'b01, 14, 0, 16'h0030); cmt(14, 32'h999); tick();
    op(2'b10, 15, 14, 16'h0001); tick();
    cur_req = "R6";
    op(2'b00, 16, 1, 16'h0, 0, 1); tick();
    op(2'b00, 16, 1, 16'h0, 0, 1); tick();
    cmt(16, 32'h111); tick();
    op(2'b11, 0, 16, 16'h0); tick();
    cmt(16, 32'h222); tick();
    op(2'b11, 0, 16, 16'h0); tick();
    cur_req = "R9";
    op(2'b01, 0, 5, 16'h0005); tick();
    op(2'b00, 0, 5, 16'h0, 0, 1); tick();
    op(2'b10, 17, 0, 16'h7FFC); tick();
    cur_req = "R10";
    for (int r = 1; r < 32; r++) begin
      while (m_pd[r] > 0) begin cmt(r, 32'(r * 16)); tick(); end
    end
    op(2'b11, 0, 3, 16'h0); tick();
    cur_req = "R8";
    for (int n = 0; n < 3000; n++) begin
      int rd, rs, o;
      rd = $urandom_range(0, 7); rs = $urandom_range(0, 7); o = $urandom_range(0, 3);
      if ($urandom_range(0, 9) < 8) begin
        if (m_pd[rd] >= 6 && o != 3) o = 1;
        if (o == 1 && m_pd[rd] >= 6 && !m_trk[rs]) o = 3;
        op(2'(o), rd, rs, 16'($urandom), 1'($urandom), 1'($urandom));
      end
      if ($urandom_range(0, 2) == 0) begin
        int st;
        st = $urandom_range(1, 7);
        for (int k = 0; k < 7; k++) begin
          int r;
          r = ((st + k - 1) % 7) + 1;
          if (m_pd[r] > 0 && !cmt_valid) cmt(r, $urandom);
        end
      end
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule